// File: doc/BRIEF.md
# Event Timestamp Capture Slots

This block takes a free-running 64-bit time value and freezes a copy of it when an event strobe fires. There are two independent slots, one fed by a transmit-side strobe and one by a receive-side strobe. A typical strobe source is the logic that spots the start of a frame of interest. Each slot holds one stamp and then locks. Later strobes cannot overwrite the held value, so software can always tie the stored stamp to the first event after it re-armed the slot. Software reads the stamp as a low word and a high word. Reading the high word releases the slot.

Each slot is a two-state machine. In state `SLOT_ARMED`, the transition *capture* (enable set and strobe high) copies the time value and moves to `SLOT_HELD`. In `SLOT_HELD`, the transition *release* (a read of that slot's high word) returns the machine to `SLOT_ARMED`. Any other input leaves the state unchanged. A strobe that arrives in `SLOT_HELD` is dropped and sets a sticky overrun flag. Software polls the valid flag to learn that a stamp is waiting. For the transmit slot it can also use the interrupt line, which is gated by a mask bit.

The register port has a 3-bit word address. `reg_rdata` is combinational from the address. Read side effects and writes take effect at the rising clock edge while `reg_rd` or `reg_wr` is high.

Top module: `ts_capture_top`

## Requirements
- R1: After reset both slots are disabled and empty, every register reads 0, and `irq_tx` is low.
- R2: The control word of the transmit slot is at address 0 and that of the receive slot at address 3. In each control word, bit0 is enable (read/write), bit1 is valid (read-only) and bit2 is overrun (read-only). A strobe on an enabled, empty slot copies `time_in` at that clock edge and sets valid. The copy then reads at the low-word address (1 for transmit, 4 for receive) as bits 31:0 and at the high-word address (2 for transmit, 5 for receive) as bits 63:32.
- R3: While valid is set, further strobes leave the held stamp unchanged.
- R4: A read of a slot's high word clears its valid bit, so the next strobe is captured.
- R5: A strobe on a slot whose enable bit is 0 captures nothing, and valid stays 0.
- R6: Writing enable to 0 while a stamp is held keeps both valid and the stamp.
- R7: If a high-word read and a strobe reach the same slot in one cycle, the read wins. The strobe is dropped, and the slot ends up empty.
- R8: A strobe dropped while the slot is held, including the case in R7, sets overrun. A read of that slot's control word clears overrun after returning it.
- R9: Bit0 of address 6 is the transmit interrupt mask (read/write). `irq_tx` is high exactly while the transmit slot is valid and the mask is 1. Receive captures never raise it.
- R10: The two slots are independent. Strobes, reads and writes for one slot never change the other slot's state. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_in | input | 64 | Running time value to capture |
| tx_evt | input | 1 | Transmit event strobe |
| rx_evt | input | 1 | Receive event strobe |
| reg_addr | input | 3 | Register word address |
| reg_rd | input | 1 | Read strobe, side effects at clock edge |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 1 | Write data bit (enable or mask) |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_tx | output | 1 | Transmit stamp interrupt |

## Verification
The hardest case to reach from the ports is a high-word read that lands in the same clock cycle as a strobe. Both must be held high across a single edge. To get there, the bench drives the read strobe and the event strobe together in one task, after a first capture has locked the slot. It then checks three things: the control word shows the slot empty with overrun set, and a following strobe captures its own time value rather than the dropped one.

// File: rtl/ts_capture_pkg.sv
package ts_capture_pkg;
    parameter int TIME_W = 64;
    parameter int WORD_W = 32;
    localparam int HALF_W = TIME_W / 2;

    typedef enum logic {
        SLOT_ARMED = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_e;

    typedef enum logic [2:0] {
        A_TX_CTRL = 3'd0,
        A_TX_LO   = 3'd1,
        A_TX_HI   = 3'd2,
        A_RX_CTRL = 3'd3,
        A_RX_LO   = 3'd4,
        A_RX_HI   = 3'd5,
        A_IRQ_MSK = 3'd6,
        A_NONE    = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/ts_slot.sv
module ts_slot
    import ts_capture_pkg::*;
#(
    parameter int TW = TIME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          evt,
    input  logic [TW-1:0] time_in,
    input  logic          rd_hi,
    input  logic          rd_ctrl,
    output logic          valid,
    output logic          overrun,
    output logic [TW-1:0] stamp
);
    slot_state_e state_q, state_d;
    logic        take;
    logic        drop;

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            SLOT_ARMED: begin
                if (en && evt) begin
                    state_d = SLOT_HELD;
                    take    = 1'b1;
                end
            end
            SLOT_HELD: begin
                if (rd_hi) state_d = SLOT_ARMED;
            end
            default: state_d = SLOT_ARMED;
        endcase
    end

    assign drop = evt && (state_q == SLOT_HELD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_ARMED;
            stamp   <= '0;
            overrun <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take) stamp <= time_in;
            if (drop) overrun <= 1'b1;
            else if (rd_ctrl) overrun <= 1'b0;
        end
    end

    always_comb begin
        valid = (state_q == SLOT_HELD);
    end

    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && en && evt) |=> (valid && stamp == $past(time_in))) else $error("capture"); // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !rd_hi) |=> (valid && $stable(stamp))) else $error("hold"); // R3
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && rd_hi) |=> !valid) else $error("release"); // R4
    AST_NO_CAPTURE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !en) |=> !valid) else $error("disabled"); // R5
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && evt) |=> overrun) else $error("overrun"); // R8
endmodule

// File: rtl/ts_capture_top.sv
module ts_capture_top
    import ts_capture_pkg::*;
#(
    parameter int TW = TIME_W,
    parameter int DW = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] time_in,
    input  logic          tx_evt,
    input  logic          rx_evt,
    input  logic [2:0]    reg_addr,
    input  logic          reg_rd,
    input  logic          reg_wr,
    input  logic          reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_tx
);
    localparam int NSLOT = 2;

    logic [NSLOT-1:0] en_q, evt, rd_hi, rd_ctrl, valid, ovr;
    logic [TW-1:0]    stamp [NSLOT];
    logic             mask_q;
    reg_addr_e        addr;

    assign addr = reg_addr_e'(reg_addr);
    assign evt  = {rx_evt, tx_evt};

    assign rd_hi[0]   = reg_rd && addr == A_TX_HI;
    assign rd_hi[1]   = reg_rd && addr == A_RX_HI;
    assign rd_ctrl[0] = reg_rd && addr == A_TX_CTRL;
    assign rd_ctrl[1] = reg_rd && addr == A_RX_CTRL;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        ts_slot #(.TW(TW)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en_q[g]),
            .evt    (evt[g]),
            .time_in(time_in),
            .rd_hi  (rd_hi[g]),
            .rd_ctrl(rd_ctrl[g]),
            .valid  (valid[g]),
            .overrun(ovr[g]),
            .stamp  (stamp[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            mask_q <= 1'b0;
        end else if (reg_wr) begin
            if (addr == A_TX_CTRL) en_q[0] <= reg_wdata;
            if (addr == A_RX_CTRL) en_q[1] <= reg_wdata;
            if (addr == A_IRQ_MSK) mask_q  <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (addr)
            A_TX_CTRL: reg_rdata[2:0] = {ovr[0], valid[0], en_q[0]};
            A_TX_LO:   reg_rdata = stamp[0][DW-1:0];
            A_TX_HI:   reg_rdata = stamp[0][TW-1:TW-DW];
            A_RX_CTRL: reg_rdata[2:0] = {ovr[1], valid[1], en_q[1]};
            A_RX_LO:   reg_rdata = stamp[1][DW-1:0];
            A_RX_HI:   reg_rdata = stamp[1][TW-1:TW-DW];
            A_IRQ_MSK: reg_rdata[0] = mask_q;
            default:   reg_rdata = '0;
        endcase
    end

    assign irq_tx = valid[0] & mask_q;

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_tx) |-> mask_q) else $error("irq"); // R9
    AST_RX_SEPARATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_evt && !rd_hi[0] && !(reg_wr && addr == A_TX_CTRL)) |=> $stable(valid[0])) else $error("sep"); // R10
endmodule

// File: tb/sim_ts_capture_top.sv
module sim_ts_capture_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_in = '0;
    logic        tx_evt = 1'b0, rx_evt = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_rd = 1'b0, reg_wr = 1'b0, reg_wdata = 1'b0;
    logic [31:0] reg_rdata;
    logic        irq_tx;
    int checks = 0, errors = 0;

    always #(CLK_P/2) clk = ~clk;

    ts_capture_top u0 (.clk(clk), .rst_n(rst_n), .time_in(time_in), .tx_evt(tx_evt),
        .rx_evt(rx_evt), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_tx(irq_tx));

    typedef struct packed { logic rx; logic [63:0] t; } vec_t;
    localparam vec_t VECS [4] = '{
        '{1'b0, 64'h0123_4567_89AB_CDEF},
        '{1'b1, 64'hFEDC_BA98_7654_3210},
        '{1'b0, 64'hFFFF_FFFF_0000_0001},
        '{1'b1, 64'h0000_0001_FFFF_FFFF}};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk); #1 reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic v);
        @(negedge clk);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = v;
        @(posedge clk); #1 reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic rx, input logic [63:0] t);
        @(negedge clk);
        time_in = t;
        if (rx) rx_evt = 1'b1; else tx_evt = 1'b1;
        @(posedge clk); #1 tx_evt = 1'b0; rx_evt = 1'b0;
    endtask

    task automatic rd_hi_with_evt(input logic [63:0] t);
        @(negedge clk);
        reg_addr = 3'd2; reg_rd = 1'b1; time_in = t; tx_evt = 1'b1;
        @(posedge clk); #1 reg_rd = 1'b0; tx_evt = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d); chk("R1", d, 0);
        end
        chk("R1 irq", irq_tx, 0);
        // R5 disabled slot ignores strobe
        pulse(1'b0, 64'h55);
        rd(3'd0, d); chk("R5", d, 0);
        wr(3'd0, 1'b1); wr(3'd3, 1'b1); wr(3'd6, 1'b1);
        rd(3'd6, d); chk("R9 mask", d, 1);
        // table walk: R2 R4 R9 R10
        for (int i = 0; i < 4; i++) begin
            logic [2:0] base, other;
            base  = VECS[i].rx ? 3'd3 : 3'd0;
            other = VECS[i].rx ? 3'd0 : 3'd3;
            pulse(VECS[i].rx, VECS[i].t);
            chk("R9 irq", irq_tx, !VECS[i].rx);
            rd(base, d);  chk("R2 ctrl", d, 3);
            rd(other, d); chk("R10", d, 1);
            rd(base + 3'd1, d); chk("R2 lo", d, VECS[i].t[31:0]);
            rd(base + 3'd2, d); chk("R2 hi", d, VECS[i].t[63:32]);
            rd(base, d);  chk("R4", d, 1);
        end
        chk("R9 low", irq_tx, 0);
        // R3 / R8 lock and overrun
        pulse(1'b0, 64'hAAAA_0001_BBBB_0002);
        pulse(1'b0, 64'h1111_2222_3333_4444);
        rd(3'd0, d); chk("R8 set", d, 7);
        rd(3'd0, d); chk("R8 clear", d, 3);
        rd(3'd1, d); chk("R3 lo", d, 32'hBBBB_0002);
        rd(3'd2, d); chk("R3 hi", d, 32'hAAAA_0001);
        rd(3'd7, d); chk("R10 addr7", d, 0);
        // R6 disable keeps stamp
        pulse(1'b0, 64'h0000_0077_0000_0066);
        wr(3'd0, 1'b0);
        rd(3'd0, d); chk("R6 ctrl", d, 2);
        rd(3'd2, d); chk("R6 hi", d, 32'h77);
        rd(3'd0, d); chk("R6 empty", d, 0);
        // R7 read wins over same-cycle strobe
        wr(3'd0, 1'b1);
        pulse(1'b0, 64'h0000_00A1_0000_00A0);
        rd_hi_with_evt(64'h0000_00B1_0000_00B0);
        rd(3'd0, d); chk("R7 ctrl", d, 5);
        pulse(1'b0, 64'h0000_00C1_0000_00C0);
        rd(3'd1, d); chk("R7 next", d, 32'hC0);
        rd(3'd2, d);
        // R9 mask off
        wr(3'd6, 1'b0);
        pulse(1'b0, 64'h9);
        chk("R9 masked", irq_tx, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule